// File: doc/BRIEF.md
# Aging-Register Recency Tracker

This block keeps a small shift register, the "age", for every page frame of a memory. The age approximates how recently the frame was used. A reference to a frame sets the most significant bit of that frame's age. A periodic aging tick shifts the age of every occupied frame one place to the right. A frame that has been referenced recently therefore holds a large value, and a frame that has gone untouched decays toward zero.

From these ages the block offers two answers at all times. The first is a replacement candidate: the lowest-numbered empty frame if one exists, and otherwise the occupied frame with the smallest age, with ties going to the lowest index. The second is a per-frame flag that marks occupied frames whose age has reached zero. Such frames have dropped out of the recent working set.

Each frame is a two-state machine. In `FR_EMPTY` the frame holds no page and its age is zero. In `FR_RESIDENT` the frame holds a page. There are three transitions. LOAD goes from either state to `FR_RESIDENT` and reinitialises the age. EVICT goes from `FR_RESIDENT` to `FR_EMPTY`. HOLD/AGE keeps the frame in `FR_RESIDENT` and applies any tick and reference. The frame count and the age width are parameters.

Top module: `aging_recency_tracker`

## Requirements
- R1: After reset every frame is empty with age zero, no stale flag is set, and the candidate index is 0.
- R2: A load to a frame makes it resident with an age that has only its most significant bit (bit AGE_W-1) set.
- R3: A reference to a resident frame sets bit AGE_W-1 of its age and leaves the other bits as they were, unless a tick arrives in the same cycle.
- R4: A tick shifts the age of every resident frame right by one, with a zero entering at bit AGE_W-1.
- R5: When a tick and a reference reach the same resident frame in one cycle, the shift is applied first and then bit AGE_W-1 is set.
- R6: References and ticks have no effect on an empty frame: it stays empty and its age stays zero.
- R7: An evict to a resident frame makes it empty and clears its age to zero.
- R8: If any frame is empty, the candidate index is the lowest-numbered empty frame.
- R9: If every frame is resident, the candidate is the frame with the smallest age, and ties go to the lowest index.
- R10: The stale flag of a frame is 1 exactly when the frame is resident and its age is zero.
- R11: A load overrides any evict, reference or tick that reaches the same frame in the same cycle. The frame's age becomes the load value.
- R12: All outputs are registered state or are derived from it. The effect of an input appears in the cycle after the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | Reference strobe |
| ref_idx | input | IDX_W | Frame being referenced |
| tick | input | 1 | Aging tick for all frames |
| load_en | input | 1 | Page-load strobe |
| load_idx | input | IDX_W | Frame receiving a page |
| evict_en | input | 1 | Frame-release strobe |
| evict_idx | input | IDX_W | Frame being released |
| resident | output | N_FRAMES | Per-frame occupied flag |
| stale | output | N_FRAMES | Per-frame flag: resident with zero age |
| age_flat | output | N_FRAMES*AGE_W | All ages; frame f at bits f*AGE_W +: AGE_W |
| victim_idx | output | IDX_W | Replacement candidate |

## Verification
The bench targets the coincident cases.

- **Tick and reference together (R5).** If the design ordered the operations the wrong way, it would shift the freshly set bit down instead of keeping it at the top.
- **Load together with evict or tick (R11).** If the design gave evict priority, the frame would be left empty.
- **Empty frames receiving ticks or references (R6).** If the design let these through, an empty frame would gain a non-zero age.
- **Ties on the minimum age (R9).** If the comparison were not strict, a higher index would win the tie.
- **Empty frames against occupied frames with zero age (R8, R10).** If the design compared ages alone, it could choose an occupied zero-age frame ahead of an empty one.

A long pseudo-random sweep then compares every age, flag and the candidate against an arithmetic model after each cycle.

// File: rtl/aging_pkg.sv
package aging_pkg;

    typedef enum logic {
        FR_EMPTY    = 1'b0,
        FR_RESIDENT = 1'b1
    } frame_state_e;

endpackage

// File: rtl/aging_idx_decode.sv
module aging_idx_decode #(
    parameter int N_FRAMES = 8,
    parameter int IDX_W    = 3
) (
    input  logic                en,
    input  logic [IDX_W-1:0]    idx,
    output logic [N_FRAMES-1:0] hit
);

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_dec
        assign hit[g] = en && (idx == IDX_W'(g));
    end

endmodule

// File: rtl/aging_cell.sv
module aging_cell
    import aging_pkg::*;
#(
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ref_hit,
    input  logic             load_hit,
    input  logic             evict_hit,
    output logic             resident,
    output logic             stale,
    output logic [AGE_W-1:0] age
);

    localparam logic [AGE_W-1:0] AGE_TOP = {1'b1, {(AGE_W-1){1'b0}}};

    frame_state_e     state_q, state_d;
    logic [AGE_W-1:0] age_q, age_d;

    // State and age register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FR_EMPTY;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
        end
    end

    // Transitions: LOAD, EVICT, HOLD/AGE
    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        unique case (state_q)
            FR_EMPTY: begin
                if (load_hit) begin
                    state_d = FR_RESIDENT;
                    age_d   = AGE_TOP;
                end
            end
            FR_RESIDENT: begin
                if (load_hit) begin
                    age_d = AGE_TOP;
                end else if (evict_hit) begin
                    state_d = FR_EMPTY;
                    age_d   = '0;
                end else begin
                    if (tick) begin
                        age_d = age_q >> 1;
                    end
                    if (ref_hit) begin
                        age_d[AGE_W-1] = 1'b1;
                    end
                end
            end
            default: begin
                state_d = FR_EMPTY;
                age_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        resident = (state_q == FR_RESIDENT);
        stale    = resident && (age_q == '0);
        age      = age_q;
    end

    p_load_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |=> (state_q == FR_RESIDENT) && (age_q == AGE_TOP));

    p_ref_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_RESIDENT) && ref_hit && !load_hit && !evict_hit
        |=> age_q[AGE_W-1]);

    p_tick_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_RESIDENT) && tick && !ref_hit && !load_hit && !evict_hit
        |=> age_q == ($past(age_q) >> 1));

    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_EMPTY) && !load_hit
        |=> (state_q == FR_EMPTY) && (age_q == '0));

    p_evict_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_RESIDENT) && evict_hit && !load_hit
        |=> (state_q == FR_EMPTY) && (age_q == '0));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit && (evict_hit || tick || ref_hit) |=> age_q == AGE_TOP);

endmodule

// File: rtl/aging_victim_sel.sv
module aging_victim_sel #(
    parameter int N_FRAMES = 8,
    parameter int AGE_W    = 4,
    parameter int IDX_W    = 3
) (
    input  logic [N_FRAMES-1:0]       resident,
    input  logic [N_FRAMES*AGE_W-1:0] age_flat,
    output logic [IDX_W-1:0]          victim_idx
);

    localparam int KEY_W = AGE_W + 1;

    logic [KEY_W-1:0] key [N_FRAMES];

    // Key: occupancy above age, so empty frames (age 0) sort first
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_key
        assign key[g] = {resident[g], age_flat[g*AGE_W +: AGE_W]};
    end

    // Strict compare keeps the lowest index on ties
    always_comb begin
        logic [KEY_W-1:0] best_key;
        best_key   = key[0];
        victim_idx = '0;
        for (int i = 1; i < N_FRAMES; i++) begin
            if (key[i] < best_key) begin
                best_key   = key[i];
                victim_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/aging_recency_tracker.sv
module aging_recency_tracker #(
    parameter  int N_FRAMES = 8,
    parameter  int AGE_W    = 4,
    localparam int IDX_W    = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ref_en,
    input  logic [IDX_W-1:0]          ref_idx,
    input  logic                      tick,
    input  logic                      load_en,
    input  logic [IDX_W-1:0]          load_idx,
    input  logic                      evict_en,
    input  logic [IDX_W-1:0]          evict_idx,
    output logic [N_FRAMES-1:0]       resident,
    output logic [N_FRAMES-1:0]       stale,
    output logic [N_FRAMES*AGE_W-1:0] age_flat,
    output logic [IDX_W-1:0]          victim_idx
);

    logic [N_FRAMES-1:0] ref_hit, load_hit, evict_hit;

    aging_idx_decode #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_dec_ref (
        .en(ref_en), .idx(ref_idx), .hit(ref_hit));
    aging_idx_decode #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_dec_load (
        .en(load_en), .idx(load_idx), .hit(load_hit));
    aging_idx_decode #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_dec_evict (
        .en(evict_en), .idx(evict_idx), .hit(evict_hit));

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
        aging_cell #(.AGE_W(AGE_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .ref_hit  (ref_hit[g]),
            .load_hit (load_hit[g]),
            .evict_hit(evict_hit[g]),
            .resident (resident[g]),
            .stale    (stale[g]),
            .age      (age_flat[g*AGE_W +: AGE_W])
        );
    end

    aging_victim_sel #(.N_FRAMES(N_FRAMES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_sel (
        .resident  (resident),
        .age_flat  (age_flat),
        .victim_idx(victim_idx)
    );

    p_victim_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (~&resident) |-> !resident[victim_idx]);

    p_stale_resident_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stale & ~resident) == '0);

    p_evict_visible_r12: assert property (@(posedge clk) disable iff (!rst_n)
        evict_en && !load_en && resident[evict_idx] |=> !resident[$past(evict_idx)]);

endmodule

// File: tb/test_aging_recency_tracker.sv
module test_aging_recency_tracker;

    localparam int N  = 8;
    localparam int W  = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_en = 1'b0, tick = 1'b0, load_en = 1'b0, evict_en = 1'b0;
    logic [IW-1:0] ref_idx = '0, load_idx = '0, evict_idx = '0;
    logic [N-1:0]   resident, stale;
    logic [N*W-1:0] age_flat;
    logic [IW-1:0]  victim_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit       m_res [N];
    int       m_age [N];

    always #4 clk = ~clk;

    aging_recency_tracker #(.N_FRAMES(N), .AGE_W(W)) i_aging_recency_tracker (
        .clk(clk), .rst_n(rst_n),
        .ref_en(ref_en), .ref_idx(ref_idx), .tick(tick),
        .load_en(load_en), .load_idx(load_idx),
        .evict_en(evict_en), .evict_idx(evict_idx),
        .resident(resident), .stale(stale),
        .age_flat(age_flat), .victim_idx(victim_idx));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_victim();
        int v = -1;
        for (int f = 0; f < N; f++) if (!m_res[f] && v < 0) v = f;
        if (v < 0) begin
            v = 0;
            for (int f = 1; f < N; f++) if (m_age[f] < m_age[v]) v = f;
        end
        return v;
    endfunction

    task automatic check_all(input string tag);
        for (int f = 0; f < N; f++) begin
            chk(tag, $sformatf("resident[%0d]", f), int'(resident[f]), int'(m_res[f]));
            chk(tag, $sformatf("age[%0d]", f), int'(age_flat[f*W +: W]), m_age[f]);
            chk(tag, $sformatf("stale[%0d]", f), int'(stale[f]),
                (m_res[f] && m_age[f] == 0) ? 1 : 0);
        end
        chk(tag, "victim", int'(victim_idx), model_victim());
    endtask

    // One cycle: drive, let the edge happen, advance the model, check at negedge
    task automatic cyc(input string tag, input bit r_en, input int r_i, input bit tk,
                       input bit l_en, input int l_i, input bit e_en, input int e_i);
        ref_en = r_en; ref_idx = IW'(r_i); tick = tk;
        load_en = l_en; load_idx = IW'(l_i);
        evict_en = e_en; evict_idx = IW'(e_i);
        @(posedge clk);
        for (int f = 0; f < N; f++) begin
            if (l_en && l_i == f) begin
                m_res[f] = 1'b1; m_age[f] = 1 << (W-1);
            end else if (m_res[f]) begin
                if (e_en && e_i == f) begin
                    m_res[f] = 1'b0; m_age[f] = 0;
                end else begin
                    if (tk) m_age[f] = m_age[f] / 2;
                    if (r_en && r_i == f) m_age[f] = m_age[f] | (1 << (W-1));
                end
            end
        end
        #1;
        ref_en = 1'b0; tick = 1'b0; load_en = 1'b0; evict_en = 1'b0;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        for (int f = 0; f < N; f++) begin m_res[f] = 1'b0; m_age[f] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R6: ticks and references on empty frames
        cyc("R6 empty ref", 1, 2, 0, 0, 0, 0, 0);
        cyc("R6 empty tick+ref", 1, 5, 1, 0, 0, 0, 0);

        // R2/R8: fill frames in order, candidate is next empty
        for (int f = 0; f < N; f++) cyc("R2 R8 load", 0, 0, 0, 1, f, 0, 0);

        // R9: all equal ages tie to index 0; reference 0 moves candidate to 1
        cyc("R9 tie tick", 0, 0, 1, 0, 0, 0, 0);
        cyc("R3 ref", 1, 0, 0, 0, 0, 0, 0);
        cyc("R4 tick", 0, 0, 1, 0, 0, 0, 0);
        cyc("R5 tick+ref", 1, 3, 1, 0, 0, 0, 0);
        cyc("R3 ref keeps low bits", 1, 3, 0, 0, 0, 0, 0);
        cyc("R5 tick+ref again", 1, 3, 1, 0, 0, 0, 0);

        // R10: decay to zero flags stale
        for (int k = 0; k < W; k++) cyc("R4 R10 decay", 0, 0, 1, 0, 0, 0, 0);
        cyc("R10 ref clears stale", 1, 6, 0, 0, 0, 0, 0);

        // R7/R8: evict, then empty beats resident zero-age frames
        cyc("R7 evict", 0, 0, 0, 0, 0, 1, 4);
        cyc("R6 R8 empty ignores", 1, 4, 1, 0, 0, 0, 0);
        cyc("R7 evict low", 0, 0, 0, 0, 0, 1, 1);

        // R11: load wins against evict/ref/tick on same frame
        cyc("R11 load vs evict", 1, 2, 1, 1, 2, 1, 2);
        cyc("R11 load empty vs tick", 1, 4, 1, 1, 4, 0, 0);
        cyc("R11 reload", 0, 0, 1, 1, 1, 1, 0);

        // Sweep
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc("R4/R9 sweep", lfsr[0], int'(lfsr[3:1]), lfsr[4] & lfsr[5],
                lfsr[6] & lfsr[7] & lfsr[8], int'(lfsr[11:9]),
                lfsr[12] & lfsr[13] & lfsr[14], int'({lfsr[15], lfsr[2], lfsr[9]}));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule